// File: doc/BRIEF.md
# Dual Framebuffer with Intensity Blend

This block keeps two byte-wide pixel stores of equal depth, sized by default for a 32 by 36 panel with three colour channels (3456 bytes each). A host writes bytes by presenting an address, a data byte and a strobe. Two steering bits decide which store takes the byte, and setting both puts the same byte into both stores. A one-cycle completion pulse marks the end of a host write operation. When auto-flip is on, that pulse exchanges the roles of the two stores, so the next operation fills the other one.

The display side presents one pixel address per cycle. One cycle later it gets back a blend of the two stores at that address, each weighted by its own 8-bit level. A level of 0 removes that store's contribution and 0xFF gives it full weight. The flip exchanges the write steering and the two levels together, so the store that was just written takes over the weighting that the other store had.

Top module: `fbb_dual_blend`

## Requirements
- R1: After reset the flip state is cleared (no exchange) and `disp_pix` reads 0 until the first display read completes.
- R2: A strobe with `cfg_wen` = 2'b01 (no exchange) writes `host_data` at `host_addr` into store 0 only, and `cfg_wen` = 2'b10 writes into store 1 only.
- R3: A strobe with `cfg_wen` = 2'b11 writes the same byte at the same address into both stores.
- R4: A strobe with `host_addr` >= DEPTH writes nothing, including at the address that shares its low bits.
- R5: `disp_pix` reflects `disp_addr` and the levels as sampled one clock earlier. A write to the same address in that same cycle is not seen: the read returns the old byte.
- R6: `disp_pix` = min(255, (p0*L0 + p1*L1) >> 8), where p0 and p1 are the bytes of store 0 and store 1, and L0 and L1 are the levels applied to them.
- R7: A `host_done` pulse while `cfg_auto_flip` = 1 toggles the exchange state. While it is exchanged, `cfg_wen[0]` steers to store 1 and `cfg_wen[1]` steers to store 0. In the same state, `cfg_lvl0` weights store 1 and `cfg_lvl1` weights store 0.
- R8: A `host_done` pulse while `cfg_auto_flip` = 0 leaves the exchange state unchanged. A toggle applies from the clock after the pulse, so a write or read in the pulse cycle uses the old mapping.
- R9: A display address >= DEPTH contributes 0 from both stores.
- R10: A strobe with `cfg_wen` = 2'b00 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wen | input | 2 | Write steering bits, bit 0 for the first role and bit 1 for the second |
| cfg_auto_flip | input | 1 | Enables the role exchange on `host_done` |
| cfg_lvl0 | input | 8 | Level applied to the first role |
| cfg_lvl1 | input | 8 | Level applied to the second role |
| host_addr | input | 12 | Host write address |
| host_data | input | 8 | Host write byte |
| host_stb | input | 1 | Host write strobe |
| host_done | input | 1 | End-of-write-operation pulse |
| disp_addr | input | 12 | Display read address |
| disp_pix | output | 8 | Blended pixel, one cycle after `disp_addr` |

## Verification
The bench builds the block with DEPTH = 48 and keeps the 12-bit address. This makes the out-of-range boundary reachable with small addresses, and address 64 aliases index 0 in the store's 6-bit row select, which shows whether an ignored write leaks into a real location. With 8-bit pixels and levels, the blend table reaches both the exact-weight cases and the saturation at 255. The flip sequence uses the same small store.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  localparam int PIX_W = 8;
  localparam int LVL_W = 8;
  localparam int MIX_W = PIX_W + LVL_W + 1;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [LVL_W-1:0] lvl_t;

  // weighted sum of both stores, scaled down by the level width, clipped
  function automatic pix_t blend_mix(pix_t a, pix_t b, lvl_t la, lvl_t lb);
    logic [MIX_W-1:0]       acc;
    logic [MIX_W-LVL_W-1:0] shr;
    acc = MIX_W'(a) * MIX_W'(la) + MIX_W'(b) * MIX_W'(lb);
    shr = acc[MIX_W-1:LVL_W];
    if (shr[PIX_W]) return '1;
    return shr[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/fbb_bank.sv
module fbb_bank
  import fbb_pkg::*;
#(
  parameter int DEPTH  = 3456,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  pix_t              wd,
  input  logic [ADDR_W-1:0] ra,
  output pix_t              rd,
  output logic              wr_hit
);
  localparam int                IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  pix_t mem [DEPTH];
  logic rd_ok;

  assign wr_hit = we && (wa < LIMIT);
  assign rd_ok  = ra < LIMIT;

  always_ff @(posedge clk) begin
    if (wr_hit) mem[wa[IDX_W-1:0]] <= wd;
  end

  // read port samples the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (!rst_n)     rd <= '0;
    else if (rd_ok) rd <= mem[ra[IDX_W-1:0]];
    else            rd <= '0;
  end

  assert_oob_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ra >= LIMIT) |=> (rd == '0));
endmodule

// File: rtl/fbb_flip_ctl.sv
module fbb_flip_ctl
  import fbb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_flip,
  input  logic             done,
  input  logic [1:0]       cfg_wen,
  input  lvl_t [1:0]       cfg_lvl,
  output logic [1:0]       eff_wen,
  output lvl_t [1:0]       eff_lvl,
  output logic             swapped
);
  logic flip_evt;
  assign flip_evt = auto_flip && done;

  always_ff @(posedge clk) begin
    if (!rst_n) swapped <= 1'b0;
    else        swapped <= swapped ^ flip_evt;
  end

  for (genvar g = 0; g < 2; g++) begin : g_role
    assign eff_wen[g] = swapped ? cfg_wen[1-g] : cfg_wen[g];
    assign eff_lvl[g] = swapped ? cfg_lvl[1-g] : cfg_lvl[g];
  end

  assert_flip_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flip_evt |=> (swapped != $past(swapped)));
  assert_flip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_evt |=> $stable(swapped));
endmodule

// File: rtl/fbb_mixer.sv
module fbb_mixer
  import fbb_pkg::*;
(
  input  pix_t p0,
  input  pix_t p1,
  input  lvl_t l0,
  input  lvl_t l1,
  output pix_t mix
);
  assign mix = blend_mix(p0, p1, l0, l1);
endmodule

// File: rtl/fbb_dual_blend.sv
module fbb_dual_blend
  import fbb_pkg::*;
#(
  parameter int DEPTH  = 3456,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_wen,
  input  logic              cfg_auto_flip,
  input  logic [7:0]        cfg_lvl0,
  input  logic [7:0]        cfg_lvl1,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_data,
  input  logic              host_stb,
  input  logic              host_done,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic [7:0]        disp_pix
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  logic [1:0] eff_wen;
  lvl_t [1:0] eff_lvl;
  lvl_t [1:0] lvl_q;
  pix_t [1:0] bank_rd;
  logic [1:0] wr_hit;
  logic       swapped;

  fbb_flip_ctl u_flip (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_flip (cfg_auto_flip),
    .done      (host_done),
    .cfg_wen   (cfg_wen),
    .cfg_lvl   ({cfg_lvl1, cfg_lvl0}),
    .eff_wen   (eff_wen),
    .eff_lvl   (eff_lvl),
    .swapped   (swapped)
  );

  for (genvar g = 0; g < 2; g++) begin : g_store
    fbb_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (host_stb & eff_wen[g]),
      .wa     (host_addr),
      .wd     (host_data),
      .ra     (disp_addr),
      .rd     (bank_rd[g]),
      .wr_hit (wr_hit[g])
    );

    // levels travel with the read so both arrive at the mixer together
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[g] <= '0;
      else        lvl_q[g] <= eff_lvl[g];
    end

    assert_wr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |-> (host_stb && host_addr < LIMIT));
    assert_wr_steer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wen == 2'b00) |-> !wr_hit[g]);
  end

  fbb_mixer u_mix (
    .p0  (bank_rd[0]),
    .p1  (bank_rd[1]),
    .l0  (lvl_q[0]),
    .l1  (lvl_q[1]),
    .mix (disp_pix)
  );

  assert_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q[0] == '0 && lvl_q[1] == '0) |-> (disp_pix == '0));
  assert_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stb && cfg_wen == 2'b11 && host_addr < LIMIT) |-> (wr_hit == 2'b11));
  assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (swapped && cfg_wen == 2'b01) |-> (eff_wen == 2'b10));
endmodule

// File: tb/sim_fbb_dual_blend.sv
`timescale 1ns/1ps
module sim_fbb_dual_blend;
  localparam int DEPTH = 48;
  localparam int AW    = 12;
  localparam int NV    = 8;
  // each entry: {p0, p1, lvl0, lvl1, expected}
  localparam logic [39:0] VEC [NV] = '{
    {8'd200, 8'd0,   8'd255, 8'd0,   8'd199},
    {8'd0,   8'd100, 8'd0,   8'd128, 8'd50},
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
    {8'd128, 8'd64,  8'd128, 8'd128, 8'd96},
    {8'd10,  8'd20,  8'd0,   8'd0,   8'd0},
    {8'd255, 8'd0,   8'd255, 8'd0,   8'd254},
    {8'd100, 8'd200, 8'd255, 8'd255, 8'd255},
    {8'd1,   8'd1,   8'd255, 8'd255, 8'd1}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_wen = 0;
  logic cfg_auto_flip = 0, host_stb = 0, host_done = 0;
  logic [7:0] cfg_lvl0 = 0, cfg_lvl1 = 0, host_data = 0;
  logic [AW-1:0] host_addr = 0, disp_addr = 0;
  logic [7:0] disp_pix;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fbb_dual_blend #(.DEPTH(DEPTH), .ADDR_W(AW)) u0 (.*);

  function automatic int ref_mix(int a, int b, int la, int lb);
    int v = (a * la + b * lb) / 256;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] wen, int a, int d);
    @(negedge clk);
    cfg_wen = wen; host_addr = AW'(a); host_data = 8'(d); host_stb = 1;
    @(negedge clk);
    host_stb = 0;
  endtask

  // present address and levels, one edge later the blended value is at the port
  task automatic rd(int a, int l0, int l1, output int v);
    @(negedge clk);
    disp_addr = AW'(a); cfg_lvl0 = 8'(l0); cfg_lvl1 = 8'(l1);
    @(negedge clk);
    v = disp_pix;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk("R1 reset output", disp_pix, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", disp_pix, 0);

    for (int k = 0; k < NV; k++) begin
      wr(2'b01, k, VEC[k][39:32]);
      wr(2'b10, k, VEC[k][31:24]);
      rd(k, VEC[k][23:16], VEC[k][15:8], v);
      chk("R2/R6 table", v, VEC[k][7:0]);
      chk("R6 model", v, ref_mix(VEC[k][39:32], VEC[k][31:24], VEC[k][23:16], VEC[k][15:8]));
    end

    wr(2'b11, 20, 77);
    rd(20, 255, 0, v); chk("R3 store0", v, ref_mix(77, 0, 255, 0));
    rd(20, 0, 255, v); chk("R3 store1", v, ref_mix(0, 77, 0, 255));

    // R5: write and read the same address in one cycle
    @(negedge clk);
    cfg_wen = 2'b11; host_addr = 20; host_data = 150; host_stb = 1;
    disp_addr = 20; cfg_lvl0 = 255; cfg_lvl1 = 0;
    @(negedge clk);
    host_stb = 0;
    chk("R5 old data", disp_pix, ref_mix(77, 0, 255, 0));
    @(negedge clk);
    chk("R5 new data", disp_pix, ref_mix(150, 0, 255, 0));

    // R4: 64 shares low bits with address 0
    wr(2'b11, 64, 33);
    wr(2'b11, DEPTH, 33);
    rd(0, 255, 0, v); chk("R4 store0 addr0", v, 199);
    rd(0, 0, 255, v); chk("R4 store1 addr0", v, 0);

    rd(50, 255, 255, v);   chk("R9 oob read", v, 0);
    rd(4095, 255, 255, v); chk("R9 top read", v, 0);

    wr(2'b00, 1, 33);
    rd(1, 255, 255, v); chk("R10 no enable", v, ref_mix(0, 100, 255, 255));

    // R7: flip on done, write lands with old mapping
    @(negedge clk);
    cfg_auto_flip = 1; cfg_wen = 2'b01; host_addr = 30; host_data = 90;
    host_stb = 1; host_done = 1;
    @(negedge clk);
    host_stb = 0; host_done = 0;
    wr(2'b01, 30, 60);
    rd(30, 255, 0, v); chk("R7 lvl0 on store1", v, ref_mix(0, 60, 0, 255));
    rd(30, 0, 255, v); chk("R7 lvl1 on store0", v, ref_mix(90, 0, 255, 0));

    // R8: done without auto-flip holds
    @(negedge clk);
    cfg_auto_flip = 0; host_done = 1;
    @(negedge clk);
    host_done = 0;
    rd(30, 255, 0, v); chk("R8 hold", v, 59);

    // R8: toggle applies from the clock after the pulse
    @(negedge clk);
    cfg_auto_flip = 1; host_done = 1; disp_addr = 30; cfg_lvl0 = 255; cfg_lvl1 = 0;
    @(negedge clk);
    host_done = 0;
    chk("R8 pulse cycle old map", disp_pix, 59);
    @(negedge clk);
    chk("R7 flipped back", disp_pix, 89);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule